// File: doc/BRIEF.md
# Two-Level Paired-Page Address Translator

The block turns a 64-bit virtual address into a 36-bit physical address for load and store requests in the same cycle the request is presented. Low user-space addresses are looked up in a small fully associative micro-TLB and, if that misses, in a larger fully associative joint TLB. Each entry maps two adjacent 4 KB pages, with one virtual address bit picking which half applies. All other addresses skip translation and use a fixed direct window into physical memory.

Alongside the physical address the block returns a 3-bit cache attribute, a one-hot exception code and a tag naming which structure served the lookup. A joint-TLB hit copies the entry into the micro-TLB so later accesses to the same page pair hit there. Entries are loaded only through a write port into the joint TLB. Each write flushes the micro-TLB, so the micro-TLB never holds stale copies.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no joint or micro entry is valid, so any aligned lookup of an address below 0x8000_0000 reports a miss.
- R2: A request whose address bits 2..0 are not all zero raises the alignment exception (code bit 0). This takes priority over every other exception and leaves both TLBs untouched. The source tag is 0.
- R3: An aligned request whose address bits 63..31 are not all zero bypasses translation. The physical address is address bits 28..0 zero-extended, the attribute is 3, no exception is raised and the source tag is 0.
- R4: An entry matches when its stored 27-bit page-pair number equals address bits 39..13. Address bit 12 picks the even half (0) or the odd half (1). A half is 30 bits: frame number in bits 23..0, attribute in 26..24, writable flag D in 27, valid flag V in 28 and a global flag in 29. The global flag has no effect. The physical address is {frame number, address bits 11..0} and the attribute is that of the selected half.
- R5: An aligned user-range request that matches in neither TLB raises the miss exception (code bit 1), with source tag 0.
- R6: If the selected half has V = 0, the invalid exception (code bit 2) is raised for both reads and writes.
- R7: A write to a selected half with V = 1 and D = 0 raises the modified exception (code bit 3). A read of the same half completes normally.
- R8: The micro-TLB is searched first. The source tag is 1 for a micro hit and 2 for a joint-only hit. A joint-only hit copies the entry into the micro-TLB, so the next lookup of that pair reports tag 1.
- R9: A micro-TLB fill takes the lowest-index empty way. When every way is full, the fill takes the victim of a binary-tree pseudo-LRU. Micro hits and fills both mark their way as most recent.
- R10: A write stores the entry at the given joint index and empties the micro-TLB. When several joint entries match, the lowest index wins.
- R11: The exception code has at most one bit set and is zero while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request present |
| req_write_i | input | 1 | Request is a store |
| req_va_i | input | 64 | Virtual address |
| resp_pa_o | output | 36 | Physical address (don't-care when an exception is set) |
| resp_attr_o | output | 3 | Cache attribute |
| resp_exc_o | output | 4 | One-hot exception: 0 align, 1 miss, 2 invalid, 3 modified |
| resp_src_o | output | 2 | 0 none, 1 micro-TLB, 2 joint TLB |
| wr_en_i | input | 1 | Joint TLB entry write |
| wr_idx_i | input | 6 | Joint TLB index to write |
| wr_vpn2_i | input | 27 | Page-pair number of the written entry |
| wr_even_i | input | 30 | Even half of the written entry |
| wr_odd_i | input | 30 | Odd half of the written entry |

## Verification
Directed lookups walk one entry through a first joint hit, then a micro hit, then both halves under reads and writes. This separates half selection, the D-flag check on writes, and micro refill. Corner addresses sit just below and at 0x8000_0000 and include misaligned kernel addresses. These show where the bypass window starts and that alignment wins over it. A five-page sweep over four micro ways checks the empty-way-first rule and which way the tree evicts. Duplicate joint entries check the lowest-index priority. Random lookups over a small pool of page pairs, mixed with reloads and bypass and misaligned addresses, are compared against a reference model of both TLBs and their recency state.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  localparam int VA_W    = 64;
  localparam int PA_W    = 36;
  localparam int VPN2_W  = 27;
  localparam int PFN_W   = 24;
  localparam int ATTR_W  = 3;
  localparam int PAGE_W  = 12;
  localparam int ALIGN_W = 3;
  localparam int SEG_BIT = 31;  // user range ends below 2^31
  localparam int WIN_W   = 29;  // direct window width
  localparam int EXC_W   = 4;
  localparam int EXC_ALIGN = 0;
  localparam int EXC_MISS  = 1;
  localparam int EXC_INVAL = 2;
  localparam int EXC_MOD   = 3;
  localparam logic [ATTR_W-1:0] ATTR_BYPASS = 3'd3;

  typedef struct packed {
    logic              g;
    logic              v;
    logic              d;
    logic [ATTR_W-1:0] attr;
    logic [PFN_W-1:0]  pfn;
  } half_t;

  localparam int HALF_W = $bits(half_t);

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    half_t             odd;
    half_t             even;
  } entry_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MICRO = 2'd1,
    SRC_JOINT = 2'd2
  } src_e;
endpackage

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAYS-2:0] tree_q, tree_d;

  always_comb begin
    int n;
    n = 0;
    victim_o = '0;
    for (int l = 0; l < WAY_W; l++) begin
      victim_o[WAY_W-1-l] = tree_q[n];
      n = 2*n + 1 + int'(tree_q[n]);
    end
  end

  // point every node on the touched path away from the touched way
  always_comb begin
    int m;
    m = 0;
    tree_d = tree_q;
    if (touch_i) begin
      for (int l = 0; l < WAY_W; l++) begin
        tree_d[m] = ~touch_way_i[WAY_W-1-l];
        m = 2*m + 1 + int'(touch_way_i[WAY_W-1-l]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tree_q <= '0;
    else         tree_q <= tree_d;
  end

  // R9
  plru_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (victim_o != $past(touch_way_i)));
endmodule

// File: rtl/tlb_micro.sv
module tlb_micro
  import tlb_xlate_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN2_W-1:0] vpn2_i,
  output logic              hit_o,
  output entry_t            entry_o,
  input  logic              touch_i,
  input  logic              fill_i,
  input  entry_t            fill_entry_i,
  input  logic              flush_i
);
  logic [WAYS-1:0]  valid_q;
  entry_t           ent_q [WAYS];
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, free_way, plru_victim, fill_way, upd_way;
  logic             upd;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[w] && (ent_q[w].vpn2 == vpn2_i);
  end

  always_comb begin
    hit_way = '0;
    entry_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
        entry_o = ent_q[w];
      end
    end
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!valid_q[w]) free_way = WAY_W'(w);
  end

  assign hit_o    = |hit_vec;
  assign fill_way = (&valid_q) ? plru_victim : free_way;
  assign upd      = fill_i | (touch_i & hit_o);
  assign upd_way  = fill_i ? fill_way : hit_way;

  tlb_plru #(.WAYS(WAYS)) u_plru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (upd),
    .touch_way_i (upd_way),
    .victim_o    (plru_victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (fill_i)  valid_q[fill_way] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) ent_q[fill_way] <= fill_entry_i;
  end

  // R8
  micro_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R10
  micro_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  // R9
  micro_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i) |=> (valid_q[$past(fill_way)] &&
                              ent_q[$past(fill_way)].vpn2 == $past(fill_entry_i.vpn2)));
endmodule

// File: rtl/tlb_joint.sv
module tlb_joint
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  entry_t            wr_entry_i,
  input  logic [VPN2_W-1:0] vpn2_i,
  output logic              hit_o,
  output entry_t            entry_o
);
  logic [ENTRIES-1:0] valid_q;
  entry_t             ent_q [ENTRIES];

  // lowest index wins
  always_comb begin
    hit_o   = 1'b0;
    entry_o = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (valid_q[i] && ent_q[i].vpn2 == vpn2_i) begin
        hit_o   = 1'b1;
        entry_o = ent_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) ent_q[wr_idx_i] <= wr_entry_i;
  end

  // R10
  joint_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (valid_q[$past(wr_idx_i)] && ent_q[$past(wr_idx_i)] == $past(wr_entry_i)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int MICRO_WAYS    = 4,
  parameter int JOINT_ENTRIES = 64,
  localparam int JIDX_W = $clog2(JOINT_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic [PA_W-1:0]   resp_pa_o,
  output logic [ATTR_W-1:0] resp_attr_o,
  output logic [EXC_W-1:0]  resp_exc_o,
  output logic [1:0]        resp_src_o,
  input  logic              wr_en_i,
  input  logic [JIDX_W-1:0] wr_idx_i,
  input  logic [VPN2_W-1:0] wr_vpn2_i,
  input  logic [HALF_W-1:0] wr_even_i,
  input  logic [HALF_W-1:0] wr_odd_i
);
  logic              aligned, in_user, active, fill;
  logic [VPN2_W-1:0] vpn2;
  logic              micro_hit, joint_hit, found;
  entry_t            micro_ent, joint_ent, sel_ent, wr_entry;
  half_t             sel_half;
  logic              unused_gbit;

  assign aligned  = (req_va_i[ALIGN_W-1:0] == '0);
  assign in_user  = (req_va_i[VA_W-1:SEG_BIT] == '0);
  assign vpn2     = req_va_i[PAGE_W+VPN2_W:PAGE_W+1];
  assign active   = req_valid_i && aligned && in_user && !wr_en_i;
  assign wr_entry = {wr_vpn2_i, wr_odd_i, wr_even_i};

  tlb_micro #(.WAYS(MICRO_WAYS)) u_micro (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vpn2_i       (vpn2),
    .hit_o        (micro_hit),
    .entry_o      (micro_ent),
    .touch_i      (active),
    .fill_i       (fill),
    .fill_entry_i (joint_ent),
    .flush_i      (wr_en_i)
  );

  tlb_joint #(.ENTRIES(JOINT_ENTRIES)) u_joint (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .vpn2_i     (vpn2),
    .hit_o      (joint_hit),
    .entry_o    (joint_ent)
  );

  assign fill        = active && !micro_hit && joint_hit;
  assign found       = micro_hit || joint_hit;
  assign sel_ent     = micro_hit ? micro_ent : joint_ent;
  assign sel_half    = req_va_i[PAGE_W] ? sel_ent.odd : sel_ent.even;
  assign unused_gbit = sel_half.g;

  always_comb begin
    resp_exc_o = '0;
    if (req_valid_i) begin
      if (!aligned)                           resp_exc_o[EXC_ALIGN] = 1'b1;
      else if (in_user) begin
        if (!found)                           resp_exc_o[EXC_MISS]  = 1'b1;
        else if (!sel_half.v)                 resp_exc_o[EXC_INVAL] = 1'b1;
        else if (req_write_i && !sel_half.d)  resp_exc_o[EXC_MOD]   = 1'b1;
      end
    end
  end

  always_comb begin
    resp_src_o = SRC_NONE;
    if (req_valid_i && aligned && in_user)
      resp_src_o = micro_hit ? SRC_MICRO : (joint_hit ? SRC_JOINT : SRC_NONE);
  end

  assign resp_pa_o   = in_user ? {sel_half.pfn, req_va_i[PAGE_W-1:0]}
                               : PA_W'(req_va_i[WIN_W-1:0]);
  assign resp_attr_o = in_user ? sel_half.attr : ATTR_BYPASS;

  // R11
  exc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(resp_exc_o));
  // R11
  exc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (resp_exc_o == '0));
  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_va_i[ALIGN_W-1:0] == '0 && req_va_i[VA_W-1:SEG_BIT] != '0)
      |-> (resp_exc_o == '0 && resp_attr_o == ATTR_BYPASS &&
           resp_pa_o == PA_W'(req_va_i[WIN_W-1:0]) && resp_src_o == SRC_NONE));
  // R8
  refill_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && resp_src_o == SRC_JOINT) |=> (req_valid_i && !wr_en_i &&
      req_va_i == $past(req_va_i) |-> resp_src_o == SRC_MICRO));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  import tlb_xlate_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int JN = 64;
  localparam int MW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_va = '0;
  logic [35:0] resp_pa;
  logic [2:0]  resp_attr;
  logic [3:0]  resp_exc;
  logic [1:0]  resp_src;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [26:0] wr_vpn2 = '0;
  logic [29:0] wr_even = '0, wr_odd = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  entry_t   jt_m [JN];
  bit       jt_vm [JN];
  entry_t   mt_m [MW];
  bit       mt_vm [MW];
  bit [2:0] tree_m;
  logic [26:0] pool [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_va_i(req_va),
    .resp_pa_o(resp_pa), .resp_attr_o(resp_attr), .resp_exc_o(resp_exc), .resp_src_o(resp_src),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn2_i(wr_vpn2),
    .wr_even_i(wr_even), .wr_odd_i(wr_odd)
  );

  function automatic half_t mk_half(bit g, bit v, bit d, bit [2:0] a, bit [23:0] p);
    return half_t'({g, v, d, a, p});
  endfunction

  function automatic logic [63:0] mk_va(logic [26:0] v2, bit odd, logic [11:0] off);
    return {24'h0, v2, odd, off};
  endfunction

  function automatic void predict(input bit wr, input logic [63:0] va,
                                  output logic [3:0] exc, output logic [35:0] pa,
                                  output logic [2:0] attr, output logic [1:0] src,
                                  output int mway, output int jidx);
    entry_t e;
    half_t  h;
    logic [26:0] v2;
    exc = '0; pa = '0; attr = '0; src = '0; mway = -1; jidx = -1; e = '0;
    v2 = va[39:13];
    if (va[2:0] != 3'b0) begin exc = 4'b0001; return; end
    if (va[63:31] != '0) begin pa = {7'b0, va[28:0]}; attr = 3'd3; return; end
    for (int w = 0; w < MW; w++)
      if (mt_vm[w] && mt_m[w].vpn2 == v2 && mway < 0) mway = w;
    if (mway >= 0) begin
      e = mt_m[mway]; src = 2'd1;
    end else begin
      for (int i = 0; i < JN; i++)
        if (jt_vm[i] && jt_m[i].vpn2 == v2 && jidx < 0) jidx = i;
      if (jidx < 0) begin exc = 4'b0010; return; end
      e = jt_m[jidx]; src = 2'd2;
    end
    h = va[12] ? e.odd : e.even;
    if (!h.v) exc = 4'b0100;
    else if (wr && !h.d) exc = 4'b1000;
    pa = {h.pfn, va[11:0]};
    attr = h.attr;
  endfunction

  function automatic void touch_m(int w);
    int n = 0;
    for (int l = 0; l < 2; l++) begin
      int dir = (w >> (1 - l)) & 1;
      tree_m[n] = (dir == 0);
      n = 2*n + 1 + dir;
    end
  endfunction

  function automatic int victim_m();
    int n = 0, v = 0;
    for (int w = 0; w < MW; w++) if (!mt_vm[w]) return w;
    for (int l = 0; l < 2; l++) begin
      int dir = int'(tree_m[n]);
      v = v*2 + dir;
      n = 2*n + 1 + dir;
    end
    return v;
  endfunction

  task automatic lookup(string tag, bit wr, logic [63:0] va);
    logic [3:0] e_exc; logic [35:0] e_pa; logic [2:0] e_attr; logic [1:0] e_src;
    int mway, jidx, w;
    bit ok;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b1; req_write = wr; req_va = va;
    #2;
    predict(wr, va, e_exc, e_pa, e_attr, e_src, mway, jidx);
    checks++;
    ok = (resp_exc == e_exc) && (resp_src == e_src) &&
         (e_exc != 4'b0 || (resp_pa == e_pa && resp_attr == e_attr));
    if (!ok) begin
      fails++;
      $display("FAIL %s va=%h wr=%0d: act exc=%b src=%0d pa=%h attr=%0d exp exc=%b src=%0d pa=%h attr=%0d",
               tag, va, wr, resp_exc, resp_src, resp_pa, resp_attr, e_exc, e_src, e_pa, e_attr);
    end
    @(posedge clk);
    if (va[2:0] == 3'b0 && va[63:31] == '0) begin
      if (mway >= 0) touch_m(mway);
      else if (jidx >= 0) begin
        w = victim_m();
        mt_m[w] = jt_m[jidx]; mt_vm[w] = 1'b1;
        touch_m(w);
      end
    end
  endtask

  task automatic jwrite(int idx, logic [26:0] v2, half_t ev, half_t od);
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn2 = v2;
    wr_even = ev; wr_odd = od;
    @(posedge clk);
    jt_m[idx] = {v2, od, ev}; jt_vm[idx] = 1'b1;
    for (int w = 0; w < MW; w++) mt_vm[w] = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0; req_va = 64'h1000;
    #2;
    checks++;
    if (resp_exc != 4'b0 || resp_src != 2'd0) begin
      fails++;
      $display("FAIL %s idle: act exc=%b src=%0d exp exc=0000 src=0", tag, resp_exc, resp_src);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    half_t ha, hb;
    void'($urandom(32'd20240));
    for (int i = 0; i < JN; i++) begin jt_vm[i] = 1'b0; jt_m[i] = '0; end
    for (int w = 0; w < MW; w++) begin mt_vm[w] = 1'b0; mt_m[w] = '0; end
    tree_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 R11: reset state and idle
    idle_check("R11");
    lookup("R1", 1'b0, 64'h2000);
    lookup("R5", 1'b0, 64'h7FFF_FFF8);

    // R4 R8: first joint hit then micro hit, both halves
    jwrite(5, 27'h10, mk_half(0, 1, 1, 3'd3, 24'hABCDE), mk_half(1, 1, 0, 3'd2, 24'h12345));
    lookup("R8", 1'b0, mk_va(27'h10, 0, 12'h0A8));
    lookup("R8", 1'b0, mk_va(27'h10, 0, 12'h0A8));
    lookup("R4", 1'b0, mk_va(27'h10, 1, 12'h010));
    lookup("R7", 1'b1, mk_va(27'h10, 1, 12'h010));
    lookup("R7", 1'b1, mk_va(27'h10, 0, 12'hFF8));

    // R2: misaligned user and kernel addresses
    lookup("R2", 1'b0, mk_va(27'h10, 0, 12'h004));
    lookup("R2", 1'b1, 64'hFFFF_FFFF_8000_0001);

    // R3: bypass window edges
    lookup("R3", 1'b0, 64'hFFFF_FFFF_8000_1238);
    lookup("R3", 1'b1, 64'h0000_0000_8000_0000);
    lookup("R3", 1'b0, 64'h4000_0000_1FFF_FFF8);

    // R6: invalid half on read and write
    jwrite(6, 27'h22, mk_half(0, 0, 1, 3'd1, 24'h00777), mk_half(0, 1, 1, 3'd0, 24'h00888));
    lookup("R6", 1'b0, mk_va(27'h22, 0, 12'h100));
    lookup("R6", 1'b1, mk_va(27'h22, 0, 12'h100));
    lookup("R4", 1'b1, mk_va(27'h22, 1, 12'h100));

    // R10: duplicates resolve to lowest index; write flushes micro
    jwrite(9, 27'h33, mk_half(0, 1, 1, 3'd5, 24'h0000B), mk_half(0, 1, 1, 3'd5, 24'h0000B));
    jwrite(2, 27'h33, mk_half(0, 1, 1, 3'd4, 24'h0000A), mk_half(0, 1, 1, 3'd4, 24'h0000A));
    lookup("R10", 1'b0, mk_va(27'h33, 0, 12'h008));
    lookup("R10", 1'b0, mk_va(27'h10, 0, 12'h000));

    // R9: fill order and tree victim over five page pairs
    for (int k = 0; k < 5; k++)
      jwrite(10 + k, 27'(27'h100 + k), mk_half(0, 1, 1, 3'(k), 24'(24'h500 + k)),
             mk_half(0, 1, 1, 3'(k), 24'(24'h600 + k)));
    for (int k = 0; k < 5; k++) lookup("R9", 1'b0, mk_va(27'(27'h100 + k), 0, 12'h0));
    lookup("R9", 1'b0, mk_va(27'h100, 0, 12'h0));
    lookup("R9", 1'b0, mk_va(27'h101, 1, 12'h0));
    lookup("R9", 1'b0, mk_va(27'h102, 0, 12'h0));

    // random mix
    for (int p = 0; p < 8; p++) pool[p] = 27'($urandom_range(0, (1 << 18) - 1));
    for (int t = 0; t < 400; t++) begin
      int sel = $urandom_range(0, 99);
      if (sel < 8) begin
        ha = half_t'(30'($urandom()));
        hb = half_t'(30'($urandom()));
        ha.v = ($urandom_range(0, 3) != 0); hb.v = ($urandom_range(0, 3) != 0);
        jwrite($urandom_range(0, 15), pool[$urandom_range(0, 7)], ha, hb);
      end else if (sel < 16) begin
        lookup("R2", 1'($urandom()), {$urandom(), $urandom()} | 64'h1);
      end else if (sel < 24) begin
        lookup("R3", 1'($urandom()), {32'h8000_0000 | $urandom(), $urandom()} & ~64'h7);
      end else if (sel < 30) begin
        lookup("R5", 1'($urandom()), {33'h0, 31'($urandom())} & ~64'h7);
      end else begin
        lookup("R8", 1'($urandom()),
               mk_va(pool[$urandom_range(0, 7)], 1'($urandom()), 12'($urandom()) & 12'hFF8));
      end
    end
    idle_check("R11");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule